// File: doc/BRIEF.md
# Fixed-Point Trap Condition Unit

This block looks at one already-fetched 32-bit instruction word together with the address it came from and the values of its two source registers. It recognises the four fixed-point trap forms: word and doubleword, each with either an immediate or a register as the second operand. It builds the second operand, runs the signed and unsigned comparisons that the 5-bit condition mask selects, and decides whether a precise trap is taken.

When the trap fires, the block reports the faulting address as the saved address and keeps the next address equal to it. It also requests the program interrupt vector and raises the trap bit of the saved machine status. For the typed-trap encoding it additionally presents the raw immediate as a type code. When no trap is taken, the next address is the sequential one. An instruction that is not a trap form is flagged as not handled and passes through as a sequential step.

Results appear one clock after an accepted input. The unit sits beside the execute stage of a pipeline, which feeds it one instruction per cycle under a valid strobe.

Top module: `trap_unit`

## Requirements
- R1: Big-endian bit numbering is used, so word bit n is vector bit 31-n. The primary opcode is `instr[31:26]`, the mask is `instr[25:21]`, the first register index is `instr[20:16]` and the immediate is `instr[15:0]`. Opcode 3 is the word-immediate form and opcode 2 the doubleword-immediate form. Opcode 31 is a register form, with extended opcode `instr[10:1]` equal to 4 for word and 68 for doubleword. These forms give `handled`=1. Any other word gives `handled`=0, `trap`=0 and `next_pc`=`pc`+4.
- R2: Within the mask, bit 4 (weight 16) selects signed less-than and bit 3 (8) selects signed greater-than. Bit 2 (4) selects equal, bit 1 (2) selects unsigned less-than and bit 0 (1) selects unsigned greater-than. The trap fires when any selected condition holds for first operand versus second operand.
- R3: The immediate forms use the 16-bit immediate, sign-extended, as the second operand.
- R4: The word forms compare only the low 32 bits of both operands, and the upper halves have no effect. The doubleword forms compare all 64 bits.
- R5: The register forms take the second operand from `opb`.
- R6: A mask of 0 never traps, and a mask of 31 always traps for any handled form.
- R7: On a trap, `saved_pc` and `next_pc` both equal the instruction's own address. Otherwise `next_pc` is that address plus 4.
- R8: On a trap, `vector` is 0x700 and `srr_trap` is 1. Without a trap, both are 0.
- R9: For the word-immediate form with mask 31 and first register index 0, `type_code` carries the raw immediate and `type_valid` is 1. Otherwise `type_valid` is 0.
- R10: Outputs are registered with a latency of one cycle, and `out_valid` follows `in_valid` one cycle later. Reset clears `out_valid`, `trap` and `type_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| opa | input | 64 | Value of the first source register |
| opb | input | 64 | Value of the second source register |
| out_valid | output | 1 | Result valid |
| handled | output | 1 | Instruction was a trap form |
| trap | output | 1 | Trap taken |
| saved_pc | output | 64 | Faulting address when trapped |
| next_pc | output | 64 | Address to continue from |
| vector | output | 64 | Interrupt vector when trapped |
| srr_trap | output | 1 | Trap bit for the saved machine status |
| type_valid | output | 1 | Typed-trap code present |
| type_code | output | 16 | Raw immediate of a typed trap |

## Verification
A trap decision and the typed-trap code can land in the same result cycle. The typed-trap encoding (word immediate, mask 31, first register 0) is sent back-to-back with near-miss encodings: first register nonzero, mask 30, and the doubleword-immediate form. The scoreboard then expects the strobe only on the exact encoding, together with the trap, the 0x700 vector and the held address. The word-versus-doubleword choice also meets the comparisons in the same cycle. Operands that differ only in their upper halves must trap under one width and not under the other.

// File: rtl/trap_unit.sv
module trap_unit #(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] TRAP_VECTOR = 64'h700
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            out_valid,
  output logic            handled,
  output logic            trap,
  output logic [XLEN-1:0] saved_pc,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] vector,
  output logic            srr_trap,
  output logic            type_valid,
  output logic [15:0]     type_code
);
  localparam int HALF = XLEN / 2;

  wire [5:0] opc  = instr[31:26];
  wire [4:0] mask = instr[25:21];
  wire [4:0] ra   = instr[20:16];
  wire [9:0] xo   = instr[10:1];
  wire [15:0] imm = instr[15:0];

  wire f_wimm = opc == 6'd3;
  wire f_dimm = opc == 6'd2;
  wire f_wreg = opc == 6'd31 && xo == 10'd4;
  wire f_dreg = opc == 6'd31 && xo == 10'd68;
  wire is_trap = f_wimm | f_dimm | f_wreg | f_dreg;
  wire is_word = f_wimm | f_wreg;

  wire [XLEN-1:0] b_raw = (f_wimm | f_dimm) ? {{(XLEN-16){imm[15]}}, imm} : opb;

  // Word forms: sign-extend the low half of both sides; one comparator then
  // serves signed and unsigned ordering of the low halves.
  wire [XLEN-1:0] ca = is_word ? {{HALF{opa[HALF-1]}}, opa[HALF-1:0]} : opa;
  wire [XLEN-1:0] cb = is_word ? {{HALF{b_raw[HALF-1]}}, b_raw[HALF-1:0]} : b_raw;

  wire lt_s = $signed(ca) < $signed(cb);
  wire gt_s = $signed(ca) > $signed(cb);
  wire eq   = ca == cb;
  wire lt_u = ca < cb;
  wire gt_u = ca > cb;

  wire [4:0] cond = {lt_s, gt_s, eq, lt_u, gt_u};
  wire fire  = is_trap && |(mask & cond);
  wire typed = fire && f_wimm && mask == 5'd31 && ra == 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      handled    <= 1'b0;
      trap       <= 1'b0;
      saved_pc   <= '0;
      next_pc    <= '0;
      vector     <= '0;
      srr_trap   <= 1'b0;
      type_valid <= 1'b0;
      type_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        handled    <= is_trap;
        trap       <= fire;
        saved_pc   <= fire ? pc : '0;
        next_pc    <= fire ? pc : pc + XLEN'(4);
        vector     <= fire ? TRAP_VECTOR : '0;
        srr_trap   <= fire;
        type_valid <= typed;
        type_code  <= typed ? imm : 16'd0;
      end else begin
        trap       <= 1'b0;
        type_valid <= 1'b0;
      end
    end
  end

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !trap);
  assert_mask_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && instr[25:21] == 5'd0 |=> !trap);
  assert_mask_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && instr[25:21] == 5'd31 && (instr[31:26] == 6'd2 || instr[31:26] == 6'd3) |=> trap);
  assert_hold_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && trap |-> saved_pc == next_pc);
  assert_seq_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> trap || next_pc == $past(pc) + XLEN'(4));
  assert_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> vector == TRAP_VECTOR && srr_trap);
  assert_typed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    type_valid |-> trap && out_valid);
  assert_unhandled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !handled |-> !trap);
endmodule

// File: tb/trap_unit_test.sv
module trap_unit_test;
  typedef struct packed {
    logic        handled;
    logic        trap;
    logic [63:0] saved;
    logic [63:0] nxt;
    logic [63:0] vec;
    logic        srr;
    logic        tv;
    logic [15:0] tc;
    logic [7:0]  req;
  } exp_t;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0] instr = 0;
  logic [63:0] pc = 0, opa = 0, opb = 0;
  logic out_valid, handled, trap, srr_trap, type_valid;
  logic [63:0] saved_pc, next_pc, vector;
  logic [15:0] type_code;
  int checks = 0, errors = 0;
  exp_t q[$];
  logic done = 0;

  trap_unit uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .pc(pc), .opa(opa), .opb(opb), .out_valid(out_valid), .handled(handled),
    .trap(trap), .saved_pc(saved_pc), .next_pc(next_pc), .vector(vector),
    .srr_trap(srr_trap), .type_valid(type_valid), .type_code(type_code));

  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_d(input int op, input int m, input int r, input logic [15:0] im);
    return {6'(op), 5'(m), 5'(r), im};
  endfunction
  function automatic logic [31:0] enc_x(input int m, input int r, input int xo);
    return {6'd31, 5'(m), 5'(r), 5'd4, 10'(xo), 1'b0};
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [63:0] p,
                                 input logic [63:0] a, input logic [63:0] b, input int rq);
    exp_t e;
    int op = int'(w[31:26]);
    int xo = int'(w[10:1]);
    logic known, word, imf, f;
    logic [63:0] bb;
    logic [4:0] c;
    imf = (op == 3) || (op == 2);
    word = (op == 3) || (op == 31 && xo == 4);
    known = imf || (op == 31 && (xo == 4 || xo == 68));
    bb = imf ? 64'($signed(w[15:0])) : b;
    if (word) begin
      c[4] = $signed(a[31:0]) < $signed(bb[31:0]);
      c[3] = $signed(a[31:0]) > $signed(bb[31:0]);
      c[2] = a[31:0] == bb[31:0];
      c[1] = a[31:0] < bb[31:0];
      c[0] = a[31:0] > bb[31:0];
    end else begin
      c[4] = $signed(a) < $signed(bb);
      c[3] = $signed(a) > $signed(bb);
      c[2] = a == bb;
      c[1] = a < bb;
      c[0] = a > bb;
    end
    f = known && ((w[25:21] & c) != 0);
    e.handled = known;
    e.trap = f;
    e.saved = f ? p : 64'd0;
    e.nxt = f ? p : p + 64'd4;
    e.vec = f ? 64'h700 : 64'd0;
    e.srr = f;
    e.tv = f && op == 3 && w[25:21] == 5'd31 && w[20:16] == 5'd0;
    e.tc = e.tv ? w[15:0] : 16'd0;
    e.req = 8'(rq);
    return e;
  endfunction

  task automatic send(input logic [31:0] w, input logic [63:0] p, input logic [63:0] a,
                      input logic [63:0] b, input int rq);
    @(negedge clk);
    in_valid = 1; instr = w; pc = p; opa = a; opb = b;
    q.push_back(model(w, p, a, b, rq));
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        exp_t e;
        string r;
        if (q.size() == 0) begin
          check("R10", "unexpected result", 1, 0);
        end else begin
          e = q.pop_front();
          r = $sformatf("R%0d", e.req);
          check(r, "handled", 64'(handled), 64'(e.handled));
          check(r, "trap", 64'(trap), 64'(e.trap));
          check(r, "next_pc", next_pc, e.nxt);
          if (e.trap) begin
            check("R7", "saved_pc", saved_pc, e.saved);
            check("R8", "vector", vector, e.vec);
            check("R8", "srr_trap", 64'(srr_trap), 64'(e.srr));
          end
          check("R9", "type_valid", 64'(type_valid), 64'(e.tv));
          if (e.tv) check("R9", "type_code", 64'(type_code), 64'(e.tc));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R10", "reset out_valid", 64'(out_valid), 0);
    check("R10", "reset trap", 64'(trap), 0);
    check("R10", "reset type_valid", 64'(type_valid), 0);
    rst_n = 1;
    // R2 aliases on word immediate: opa=5 vs imm
    send(enc_d(3, 4, 1, 16'd5), 64'h1000, 64'd5, 0, 2);      // equal
    send(enc_d(3, 24, 1, 16'd5), 64'h1004, 64'd5, 0, 2);     // not-equal, no trap
    send(enc_d(3, 24, 1, 16'd6), 64'h1008, 64'd5, 0, 2);     // not-equal, trap
    send(enc_d(3, 16, 1, 16'd6), 64'h100c, 64'd5, 0, 2);     // signed lt
    send(enc_d(3, 8, 1, 16'd6), 64'h1010, 64'd5, 0, 2);      // signed gt, none
    send(enc_d(3, 12, 1, 16'd5), 64'h1014, 64'd5, 0, 2);     // signed ge
    send(enc_d(3, 20, 1, 16'd4), 64'h1018, 64'd5, 0, 2);     // signed le, none
    // R3 sign extension: -1 immediate, unsigned vs signed
    send(enc_d(3, 2, 1, 16'hffff), 64'h2000, 64'd1, 0, 3);   // 1 <u 0xffffffff trap
    send(enc_d(3, 16, 1, 16'hffff), 64'h2004, 64'd1, 0, 3);  // 1 <s -1 false
    send(enc_d(3, 1, 1, 16'hffff), 64'h2008, 64'd1, 0, 3);   // gt_u false
    send(enc_d(2, 4, 1, 16'hffff), 64'h200c, 64'hffff_ffff_ffff_ffff, 0, 3);
    send(enc_d(3, 5, 1, 16'h8000), 64'h2010, 64'hffff_8000, 0, 3);
    send(enc_d(3, 6, 1, 16'h0010), 64'h2014, 64'h20, 0, 3);  // unsigned le, none
    // R4 word ignores upper half, doubleword does not
    send(enc_d(3, 4, 1, 16'd7), 64'h3000, 64'habcd_0000_0000_0007, 0, 4);
    send(enc_d(2, 4, 1, 16'd7), 64'h3004, 64'habcd_0000_0000_0007, 0, 4);
    send(enc_x(16, 1, 4), 64'h3008, 64'h0000_0001_8000_0000, 64'h7fff_0000_0000_0000, 4);
    send(enc_x(16, 1, 68), 64'h300c, 64'h0000_0001_8000_0000, 64'h7fff_0000_0000_0000, 4);
    // R5 register forms
    send(enc_x(2, 1, 4), 64'h4000, 64'd3, 64'd9, 5);
    send(enc_x(1, 1, 68), 64'h4004, 64'h8000_0000_0000_0000, 64'd9, 5);
    send(enc_x(8, 1, 68), 64'h4008, 64'h8000_0000_0000_0000, 64'd9, 5);
    // R6 mask extremes
    send(enc_d(3, 0, 0, 16'd0), 64'h5000, 0, 0, 6);
    send(enc_x(0, 3, 68), 64'h5004, 64'd1, 64'd2, 6);
    send(enc_x(31, 3, 4), 64'h5008, 64'd1, 64'd2, 6);
    send(enc_d(2, 31, 3, 16'h1234), 64'h500c, 64'd77, 0, 6);
    // R9 typed trap vs near misses
    send(enc_d(3, 31, 0, 16'hbeef), 64'h6000, 64'd1, 0, 9);
    send(enc_d(3, 31, 2, 16'hbeef), 64'h6004, 64'd1, 0, 9);
    send(enc_d(3, 30, 0, 16'hbeef), 64'h6008, 64'd1, 0, 9);
    send(enc_d(2, 31, 0, 16'hbeef), 64'h600c, 64'd1, 0, 9);
    // R1 non-trap words
    send(enc_d(14, 31, 0, 16'd0), 64'h7000, 0, 0, 1);
    send(enc_x(31, 0, 40), 64'h7004, 0, 0, 1);
    // R8 / R7 trap at high address
    send(enc_d(2, 4, 0, 16'd0), 64'hffff_ffff_ffff_fff0, 0, 0, 8);
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    @(negedge clk);
    check("R10", "idle out_valid", 64'(out_valid), 0);
    check("R10", "queue drained", 64'(q.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule